// File: doc/BRIEF.md
# Profile-Switched Numerically Controlled Oscillator Core

This block is the phase engine of a direct digital synthesizer. It keeps eight parameter sets (profiles). Each set holds a 32-bit frequency step, a 16-bit phase offset and a 14-bit amplitude scale. Every system clock the 32-bit phase register advances by the step of the selected profile. The block emits the top 16 phase bits plus the offset, together with the amplitude scale, for a downstream sine lookup.

A host loads profiles through a write port. Writes land in a shadow copy of the bank and change nothing at the output. The shadow bank is copied into the live bank in one step, either on an update strobe or when the 3-bit profile select moves to a new value. Both inputs are looked at only once per period of a sync clock. That clock runs at a quarter of the system clock and is also driven out, so the host can align its strobes to it.

The write port uses a valid/ready handshake. `wr_ready` is high at all times, so a write completes in every cycle where `wr_valid` is high, and the port never applies back-pressure. The output side presents a new sample every clock and has no ready input. The sample rate is fixed by the system clock, so it cannot be stalled.

Top module: `nco_profile_core`

## Requirements
- R1: While `rst` is high at a clock edge, the phase register, both banks, the current profile index (0) and the outputs all clear. After that edge `out_phase`, `out_amp`, `out_valid` and `sync_clk_o` read 0.
- R2: `sync_clk_o` counts system clocks from reset. It is low after reset edges 1, 4, 5, 8, … and high after edges 2, 3, 6, 7, …, which gives a period of four clocks with a 50 % duty cycle. The edge on which it rises is called the sample edge.
- R3: At every edge the 32-bit phase register adds the live frequency step of the current profile, wrapping modulo 2^32 with no flag.
- R4: At each edge `out_phase` takes (phase register bits 31:16 + live phase offset) modulo 2^16, using the values from before that edge.
- R5: At each edge `out_amp` takes the live amplitude scale of the current profile.
- R6: A write (`wr_valid` high) stores `wr_ftw`, `wr_pow` and `wr_asf` into shadow entry `wr_prof` only. `wr_ready` is always 1. The outputs do not change until a transfer happens.
- R7: If `upd_strobe` is high at a sample edge, all eight shadow entries are copied into the live bank at that edge.
- R8: If `prof_sel` differs from the current profile index at a sample edge, the same copy happens and the current index takes `prof_sel` at that edge.
- R9: `upd_strobe` and `prof_sel` are ignored at any edge that is not a sample edge.
- R10: After a transfer edge, the new amplitude and phase offset appear on the outputs one clock later. The new frequency step first shows in the phase increment of `out_phase` two clocks later.
- R11: A write accepted at the same edge as a transfer is not part of that transfer. It is carried over by the next transfer.
- R12: `out_valid` goes high after the first edge with `rst` low and stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_prof | input | 3 | Shadow entry to write |
| wr_ftw | input | 32 | Frequency step to store |
| wr_pow | input | 16 | Phase offset to store |
| wr_asf | input | 14 | Amplitude scale to store |
| upd_strobe | input | 1 | Update request, sampled on sync rising edge |
| prof_sel | input | 3 | Profile select, sampled on sync rising edge |
| sync_clk_o | output | 1 | System clock divided by four |
| out_valid | output | 1 | Output sample valid |
| out_phase | output | 16 | Phase word with offset added |
| out_amp | output | 14 | Amplitude scale of current profile |

## Verification
A transfer lands at the edge where `sync_clk_o` rises. The bench's reference model knows which edge that is, because it counts clocks from reset. Amplitude and offset results are due one clock after the transfer edge, and the frequency change shows in the phase step two clocks after it. The outputs are registered, so every output result is due one edge after its cause. The bench applies inputs on the falling edge, advances its model on the rising edge, and compares on the following falling edge. Directed checks sample exactly at the cycles listed in R10 and R11, and confirm that the outputs have not moved one cycle earlier.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int FTW_W = 32;
  localparam int POW_W = 16;
  localparam int ASF_W = 14;

  typedef struct packed {
    logic [FTW_W-1:0] ftw;
    logic [POW_W-1:0] pow;
    logic [ASF_W-1:0] asf;
  } prof_t;
endpackage

// File: rtl/nco_sync_div.sv
module nco_sync_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic sync_clk_o,
  output logic tick_o
);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign sync_clk_o = (cnt_q >= CW'(HALF));
  assign tick_o     = (cnt_q == CW'(HALF - 1));

  // R2
  tick_align_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> $rose(sync_clk_o));
  // R2
  sync_half_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_clk_o) |=> $stable(sync_clk_o));
endmodule

// File: rtl/nco_prof_bank.sv
module nco_prof_bank
  import nco_pkg::*;
#(
  parameter int PROF_N = 8,
  localparam int PSEL_W = $clog2(PROF_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              upd_i,
  input  logic [PSEL_W-1:0] psel_i,
  input  logic              wr_en_i,
  input  logic [PSEL_W-1:0] wr_idx_i,
  input  prof_t             wr_data_i,
  output prof_t             act_o
);
  logic [PSEL_W-1:0]       cur_q;
  prof_t [PROF_N-1:0]      act_all;
  logic                    xfer;

  assign xfer = tick_i && (upd_i || (psel_i != cur_q));

  always_ff @(posedge clk) begin
    if (rst)       cur_q <= '0;
    else if (xfer) cur_q <= psel_i;
  end

  for (genvar i = 0; i < PROF_N; i++) begin : g_ent
    prof_t sh_q;
    prof_t ac_q;
    always_ff @(posedge clk) begin
      if (rst) sh_q <= '0;
      else if (wr_en_i && (wr_idx_i == PSEL_W'(i))) sh_q <= wr_data_i;
    end
    always_ff @(posedge clk) begin
      if (rst)       ac_q <= '0;
      else if (xfer) ac_q <= sh_q;
    end
    assign act_all[i] = ac_q;
  end

  assign act_o = act_all[cur_q];

  // R9
  off_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> ($stable(cur_q) && $stable(act_all)));
  // R8
  sel_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && (psel_i != cur_q)) |=> (cur_q == $past(psel_i)));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_i || (!upd_i && psel_i == cur_q)) |=> $stable(act_o));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
  import nco_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  prof_t            act_i,
  output logic             valid_o,
  output logic [POW_W-1:0] phase_o,
  output logic [ASF_W-1:0] amp_o
);
  logic [FTW_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      phase_o <= '0;
      amp_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      acc_q   <= acc_q + act_i.ftw;
      phase_o <= acc_q[FTW_W-1 -: POW_W] + act_i.pow;
      amp_o   <= act_i.asf;
      valid_o <= 1'b1;
    end
  end

  // R12
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> valid_o);
  // R5
  amp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $stable(act_i.asf)) |=> $stable(amp_o));
endmodule

// File: rtl/nco_profile_core.sv
module nco_profile_core
  import nco_pkg::*;
#(
  parameter int PROF_N = 8,
  parameter int SYNC_DIV = 4,
  localparam int PSEL_W = $clog2(PROF_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [PSEL_W-1:0] wr_prof,
  input  logic [FTW_W-1:0]  wr_ftw,
  input  logic [POW_W-1:0]  wr_pow,
  input  logic [ASF_W-1:0]  wr_asf,
  input  logic              upd_strobe,
  input  logic [PSEL_W-1:0] prof_sel,
  output logic              sync_clk_o,
  output logic              out_valid,
  output logic [POW_W-1:0]  out_phase,
  output logic [ASF_W-1:0]  out_amp
);
  logic  tick;
  prof_t wr_data;
  prof_t act;

  assign wr_ready = 1'b1;
  assign wr_data  = '{ftw: wr_ftw, pow: wr_pow, asf: wr_asf};

  nco_sync_div #(.DIV(SYNC_DIV)) u_div (
    .clk        (clk),
    .rst        (rst),
    .sync_clk_o (sync_clk_o),
    .tick_o     (tick)
  );

  nco_prof_bank #(.PROF_N(PROF_N)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .upd_i     (upd_strobe),
    .psel_i    (prof_sel),
    .wr_en_i   (wr_valid && wr_ready),
    .wr_idx_i  (wr_prof),
    .wr_data_i (wr_data),
    .act_o     (act)
  );

  nco_phase_acc u_acc (
    .clk     (clk),
    .rst     (rst),
    .act_i   (act),
    .valid_o (out_valid),
    .phase_o (out_phase),
    .amp_o   (out_amp)
  );
endmodule

// File: tb/nco_profile_core_bench.sv
module nco_profile_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [2:0]  wr_prof = '0;
  logic [31:0] wr_ftw = '0;
  logic [15:0] wr_pow = '0;
  logic [13:0] wr_asf = '0;
  logic        upd_strobe = 1'b0;
  logic [2:0]  prof_sel = '0;
  logic        sync_clk_o, out_valid;
  logic [15:0] out_phase;
  logic [13:0] out_amp;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nco_profile_core u_nco_profile_core (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_prof(wr_prof), .wr_ftw(wr_ftw), .wr_pow(wr_pow), .wr_asf(wr_asf),
    .upd_strobe(upd_strobe), .prof_sel(prof_sel), .sync_clk_o(sync_clk_o),
    .out_valid(out_valid), .out_phase(out_phase), .out_amp(out_amp)
  );

  // reference model state
  logic [31:0] m_sh_f [8], m_ac_f [8];
  logic [15:0] m_sh_p [8], m_ac_p [8];
  logic [13:0] m_sh_a [8], m_ac_a [8];
  logic [31:0] m_acc;
  logic [15:0] m_ph;
  logic [13:0] m_amp;
  logic [2:0]  m_cur;
  logic [1:0]  m_cnt;
  logic        m_val;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_edge();
    bit tick;
    if (rst) begin
      for (int k = 0; k < 8; k++) begin
        m_sh_f[k] = 0; m_sh_p[k] = 0; m_sh_a[k] = 0;
        m_ac_f[k] = 0; m_ac_p[k] = 0; m_ac_a[k] = 0;
      end
      m_acc = 0; m_ph = 0; m_amp = 0; m_cur = 0; m_cnt = 0; m_val = 0;
      return;
    end
    tick  = (m_cnt == 2'd1);
    m_ph  = m_acc[31:16] + m_ac_p[m_cur];
    m_amp = m_ac_a[m_cur];
    m_val = 1'b1;
    m_acc = m_acc + m_ac_f[m_cur];
    if (tick && (upd_strobe || prof_sel != m_cur)) begin
      for (int k = 0; k < 8; k++) begin
        m_ac_f[k] = m_sh_f[k]; m_ac_p[k] = m_sh_p[k]; m_ac_a[k] = m_sh_a[k];
      end
      m_cur = prof_sel;
    end
    if (wr_valid) begin
      m_sh_f[wr_prof] = wr_ftw; m_sh_p[wr_prof] = wr_pow; m_sh_a[wr_prof] = wr_asf;
    end
    m_cnt = m_cnt + 2'd1;
  endfunction

  // one clock: model advances at the edge, outputs compared at the falling edge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R2 sync", 32'(sync_clk_o), 32'(m_cnt[1]));
    check("R12 valid", 32'(out_valid), 32'(m_val));
    check("R4 phase", 32'(out_phase), 32'(m_ph));
    check("R5 amp", 32'(out_amp), 32'(m_amp));
    check("R6 ready", 32'(wr_ready), 32'd1);
  endtask

  task automatic to_tick();  // next edge is a sample edge
    while (m_cnt != 2'd1) step();
  endtask

  task automatic write(logic [2:0] p, logic [31:0] f, logic [15:0] ph, logic [13:0] a);
    wr_valid = 1; wr_prof = p; wr_ftw = f; wr_pow = ph; wr_asf = a;
    step();
    wr_valid = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) step();
    // R1 reset state
    check("R1 phase", 32'(out_phase), 0);
    check("R1 amp", 32'(out_amp), 0);
    check("R1 valid", 32'(out_valid), 0);
    check("R1 sync", 32'(sync_clk_o), 0);
    rst = 0;
    step();
    check("R12 valid high", 32'(out_valid), 1);
    check("R2 low edge1", 32'(sync_clk_o), 0);
    step();
    check("R2 high edge2", 32'(sync_clk_o), 1);

    // R6: buffered write has no visible effect
    write(3'd0, 32'h8000_0000, 16'h0100, 14'h155);
    repeat (5) step();
    check("R6 amp unchanged", 32'(out_amp), 0);
    check("R6 phase unchanged", 32'(out_phase), 0);

    // R9: strobe away from sample edge ignored
    while (m_cnt != 2'd2) step();
    upd_strobe = 1; step(); upd_strobe = 0;
    repeat (5) step();
    check("R9 amp unchanged", 32'(out_amp), 0);

    // R7 / R10: strobe at sample edge, exact latency
    to_tick();
    upd_strobe = 1; step(); upd_strobe = 0;
    check("R10 amp not yet", 32'(out_amp), 0);
    step();
    check("R7 amp live", 32'(out_amp), 32'h155);
    check("R10 offset live", 32'(out_phase), 32'h0100);
    step();
    check("R10 freq first step", 32'(out_phase), 32'h8100);
    step();
    check("R3 wrap", 32'(out_phase), 32'h0100);

    // R8: profile change transfers and switches
    write(3'd3, 32'h0001_0000, 16'h0000, 14'h2AA);
    prof_sel = 3'd3;
    to_tick();
    step();
    check("R8 amp not yet", 32'(out_amp), 32'h155);
    step();
    check("R8 amp switched", 32'(out_amp), 32'h2AA);

    // R11: write at the transfer edge is held for the next transfer
    to_tick();
    wr_valid = 1; wr_prof = 3'd3; wr_ftw = 32'h0001_0000; wr_pow = 0; wr_asf = 14'h777;
    upd_strobe = 1;
    step();
    wr_valid = 0; upd_strobe = 0;
    step();
    check("R11 old value kept", 32'(out_amp), 32'h2AA);
    to_tick();
    upd_strobe = 1; step(); upd_strobe = 0; step();
    check("R11 carried over", 32'(out_amp), 32'h777);

    // random traffic against the model (R3, R4, R5, R7, R8)
    for (int n = 0; n < 4000; n++) begin
      wr_valid   = ($urandom_range(3) == 0);
      wr_prof    = 3'($urandom_range(7));
      wr_ftw     = ($urandom_range(9) == 0) ? 32'hFFFF_FFFF : $urandom;
      wr_pow     = 16'($urandom);
      wr_asf     = 14'($urandom);
      upd_strobe = ($urandom_range(7) == 0);
      if ($urandom_range(15) == 0) prof_sel = 3'($urandom_range(7));
      step();
    end
    wr_valid = 0; upd_strobe = 0;
    step();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule